// File: doc/BRIEF.md
# Linked Descriptor DMA Channel

This block is one channel of a memory-to-memory and memory-to-peripheral copy engine that is driven entirely by descriptors held in memory. Each descriptor occupies a 16-byte aligned slot of four 32-bit words. In slot order these are the link word, the source address, the destination address and a command word. When software raises the run level, the channel fetches the slot named by the first-descriptor pointer. It then moves the described number of bytes one element at a time: each element is a read from the source followed by a write to the destination. After that it follows the link to the next slot.

The command word selects the element width, the burst size, address stepping, peripheral pacing, byte reversal of the moved data and the two event enables. A link word with bit 0 set ends the chain. A link that points back to an earlier slot makes the channel loop forever, and it raises one end event for every pass over a descriptor that asks for one. Every memory access uses a single request/grant handshake, and the read data and error response are valid in the grant cycle. A bus error response halts the channel until software drops the run level.

Top module: `ldma_channel`

## Requirements
- R1: On a rising run level from the stopped state, the channel reads the four words of the slot at `first_desc_i` with bits 3:0 cleared, at offsets 0, 4, 8 and 12 in that order, with `mem_size_o` = 3. The words are the link word, the source, the destination and the command.
- R2: A descriptor with length L = command bits 12:0 moves ceil(L / width) elements. Each element is a read at the current source address followed by a write of the read data to the current destination address. The write goes out with `mem_size_o` = command bits 15:14, where 1 is a byte, 2 is a halfword, 3 is a word, and code 0 is handled as a word.
- R3: When command bit 31 is set, the source address advances by the element width after each element; when it is clear, the source stays fixed. Command bit 30 does the same for the destination.
- R4: After the last element, the channel fetches the slot at link bits 31:4 (times 16) if link bit 0 is clear. If link bit 0 is set, it halts with `stopped_o` high and issues no further request.
- R5: A link back to an earlier slot repeats the chain without end. The end event fires once per completed descriptor that has bit 21 set.
- R6: `start_evt_o` pulses for one cycle after the four words of a descriptor with command bit 22 are loaded. `end_evt_o` pulses for one cycle when a descriptor with bit 21 completes. At most one of the three event outputs is high in any cycle.
- R7: A length of 0 makes no data access, but the descriptor still completes, with its end event and its link.
- R8: If command bit 29 (source pacing) or bit 28 (destination pacing) is set, the channel waits for `periph_req_i` high before each burst. A burst is (burst bytes / width) elements, and burst code bits 17:16 give 1 = 8, 2 = 16, 3 = 32 bytes, with 0 handled as 8. With both bits clear, the channel does not wait.
- R9: With `unalign_ok_i` low, the channel clears bits 2:0 of the source and destination when it loads a descriptor. With it high, the addresses are used unchanged.
- R10: When command bit 18 is set, the written data is the read word with its four bytes in reverse order.
- R11: An error response on any granted access stops all requests and pulses `buserr_evt_o` once. `stopped_o` then stays high while run stays high. A new run requires run to go low and then high again.
- R12: With run low, the channel issues no request from the next cycle on, and `stopped_o` is high.
- R13: After reset, `stopped_o` is high, and `mem_req_o` and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run level from the control register |
| first_desc_i | input | 32 | Address of the first descriptor slot |
| unalign_ok_i | input | 1 | Allow addresses that are not 8-byte aligned |
| periph_req_i | input | 1 | Peripheral ready for the next burst |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size code (1 byte, 2 half, 3 word) |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| mem_err_i | input | 1 | Error response, valid with grant |
| start_evt_o | output | 1 | Descriptor start event |
| end_evt_o | output | 1 | Descriptor end event |
| buserr_evt_o | output | 1 | Bus error event |
| stopped_o | output | 1 | Channel idle or halted |

## Verification
The run level and the memory handshake can collide with a transfer. Run can drop in the middle of an element, while a read's data is held for its write. An error response can come back in the very cycle that would otherwise advance to the next element or link. The bench provokes both cases on long descriptors, with grant stalls in other tests. It judges them against a behavioural queue of expected accesses: every granted access must match the head of the queue, and once run falls or an error returns, the count of accesses must stay frozen.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 13;
  localparam int unsigned BCNT_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_WAIT, ST_RD, ST_WR, ST_NEXT, ST_HALT
  } state_e;

  typedef struct packed {
    logic              inc_src;
    logic              inc_tgt;
    logic              flow_src;
    logic              flow_tgt;
    logic              irq_start;
    logic              irq_end;
    logic              swap;
    logic [1:0]        size;
    logic [2:0]        step;
    logic [BCNT_W-1:0] epb;
    logic [LEN_W-1:0]  len;
  } cmd_t;
endpackage

// File: rtl/ldma_cmd_decode.sv
module ldma_cmd_decode
  import ldma_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_i,
  output cmd_t              dec_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]        sz;
  logic [BCNT_W-1:0] bbytes;
  logic              unused_bits;

  assign unused_bits = ^{cmd_i[27:23], cmd_i[20:19], cmd_i[13]};

  always_comb begin
    sz = (cmd_i[15:14] == 2'd0) ? 2'd3 : cmd_i[15:14];
    case (cmd_i[17:16])
      2'd2:    bbytes = BCNT_W'(16);
      2'd3:    bbytes = BCNT_W'(32);
      default: bbytes = BCNT_W'(8);
    endcase
    dec_o.inc_src   = cmd_i[31];
    dec_o.inc_tgt   = cmd_i[30];
    dec_o.flow_src  = cmd_i[29];
    dec_o.flow_tgt  = cmd_i[28];
    dec_o.irq_start = cmd_i[22];
    dec_o.irq_end   = cmd_i[21];
    dec_o.swap      = cmd_i[18];
    dec_o.size      = sz;
    dec_o.step      = 3'd1 << (sz - 2'd1);
    dec_o.epb       = bbytes >> (sz - 2'd1);
    dec_o.len       = cmd_i[LEN_W-1:0];
  end
endmodule

// File: rtl/ldma_swap.sv
module ldma_swap #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] d_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign d_o[8*b +: 8] = en_i ? d_i[8*(NB-1-b) +: 8] : d_i[8*b +: 8];
  end
endmodule

// File: rtl/ldma_burst_track.sv
module ldma_burst_track #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [CW-1:0] epb_i,
  output logic          last_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == epb_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  // burst position never runs past the burst length (R8)
  assert_burst_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q < epb_i));
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
  import ldma_pkg::*;
#(
  parameter int unsigned ALIGN_LSB = 3,
  parameter int unsigned LINK_LSB  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [WORD_W-1:0] first_desc_i,
  input  logic              unalign_ok_i,
  input  logic              periph_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              start_evt_o,
  output logic              end_evt_o,
  output logic              buserr_evt_o,
  output logic              stopped_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned   IDX_W      = LINK_LSB - 2;
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~((WORD_W'(1) << ALIGN_LSB) - WORD_W'(1));
  localparam logic [WORD_W-1:0] LINK_MASK  = ~((WORD_W'(1) << LINK_LSB) - WORD_W'(1));

  state_e            st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] ptr_q, next_q, src_q, tgt_q, cmd_q, data_q;
  logic [LEN_W-1:0]  rem_q;
  logic              err_q;

  cmd_t dec;
  logic xfer, fault, ok, last_elem, flow, burst_last;

  ldma_cmd_decode u_dec (.cmd_i(cmd_q), .dec_o(dec));

  ldma_burst_track #(.CW(BCNT_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(st_q == ST_LOAD),
    .step_i (st_q == ST_WR && ok),
    .epb_i  (dec.epb),
    .last_o (burst_last)
  );

  ldma_swap #(.W(WORD_W)) u_swap (.d_i(data_q), .en_i(dec.swap), .d_o(mem_wdata_o));

  assign xfer      = mem_req_o & mem_gnt_i;
  assign fault     = xfer & mem_err_i;
  assign ok        = xfer & ~mem_err_i;
  assign last_elem = rem_q <= LEN_W'(dec.step);
  assign flow      = dec.flow_src | dec.flow_tgt;

  always_comb begin
    mem_req_o  = (st_q == ST_FETCH) || (st_q == ST_RD) || (st_q == ST_WR);
    mem_we_o   = (st_q == ST_WR);
    mem_size_o = (st_q == ST_FETCH) ? 2'd3 : dec.size;
    case (st_q)
      ST_RD:   mem_addr_o = src_q;
      ST_WR:   mem_addr_o = tgt_q;
      default: mem_addr_o = ptr_q + WORD_W'({idx_q, 2'b00});
    endcase
  end

  assign start_evt_o  = (st_q == ST_LOAD) && dec.irq_start;
  assign end_evt_o    = (st_q == ST_NEXT) && dec.irq_end;
  assign buserr_evt_o = err_q;
  assign stopped_o    = (st_q == ST_IDLE) || (st_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      ptr_q  <= '0;
      next_q <= '0;
      src_q  <= '0;
      tgt_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= fault;
      if (!run_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: begin
            ptr_q <= first_desc_i & LINK_MASK;
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end
          ST_FETCH: begin
            if (fault) st_q <= ST_HALT;
            else if (ok) begin
              if (idx_q == IDX_W'(0))      next_q <= mem_rdata_i;
              else if (idx_q == IDX_W'(1)) src_q  <= mem_rdata_i;
              else if (idx_q == IDX_W'(2)) tgt_q  <= mem_rdata_i;
              else                         cmd_q  <= mem_rdata_i;
              idx_q <= idx_q + IDX_W'(1);
              if (&idx_q) st_q <= ST_LOAD;
            end
          end
          ST_LOAD: begin
            src_q <= unalign_ok_i ? src_q : (src_q & ALIGN_MASK);
            tgt_q <= unalign_ok_i ? tgt_q : (tgt_q & ALIGN_MASK);
            rem_q <= dec.len;
            if (dec.len == '0) st_q <= ST_NEXT;
            else if (flow)     st_q <= ST_WAIT;
            else               st_q <= ST_RD;
          end
          ST_WAIT: if (periph_req_i) st_q <= ST_RD;
          ST_RD: begin
            if (fault) st_q <= ST_HALT;
            else if (ok) begin
              data_q <= mem_rdata_i;
              st_q   <= ST_WR;
            end
          end
          ST_WR: begin
            if (fault) st_q <= ST_HALT;
            else if (ok) begin
              if (dec.inc_src) src_q <= src_q + WORD_W'(dec.step);
              if (dec.inc_tgt) tgt_q <= tgt_q + WORD_W'(dec.step);
              rem_q <= last_elem ? '0 : rem_q - LEN_W'(dec.step);
              if (last_elem)               st_q <= ST_NEXT;
              else if (burst_last && flow) st_q <= ST_WAIT;
              else                         st_q <= ST_RD;
            end
          end
          ST_NEXT: begin
            if (next_q[0]) st_q <= ST_HALT;
            else begin
              ptr_q <= next_q & LINK_MASK;
              idx_q <= '0;
              st_q  <= ST_FETCH;
            end
          end
          default: st_q <= ST_HALT;
        endcase
      end
    end
  end

  // request held with stable address until granted (R2)
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && run_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_err_halts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && mem_err_i) |=> (!mem_req_o && stopped_o && buserr_evt_o));

  assert_run_low_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!mem_req_o && stopped_o));

  assert_evt_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_evt_o, end_evt_o, buserr_evt_o}));

  assert_burst_paced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && $past(st_q) == ST_WAIT) |-> $past(periph_req_i));
endmodule

// File: tb/sim_ldma_channel.sv
module sim_ldma_channel;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b0;
  logic [31:0] first_desc = '0;
  logic        unal = 1'b1;
  logic        periph = 1'b1;
  logic        req, we, gnt, err;
  logic [31:0] addr, wdata, rdata;
  logic [1:0]  size;
  logic        start_evt, end_evt, buserr_evt, stopped;

  always #10 clk = ~clk; // 50 MHz

  logic [31:0] dmem [0:63];
  bit          err_en = 0;
  logic [31:0] err_addr = '0;
  bit          stall = 0;
  int          gcnt = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h3c5a};
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  assign rdata = (addr < 32'd256) ? dmem[addr[7:2]] : pat(addr);
  assign err   = err_en && (addr == err_addr);

  always @(negedge clk) begin
    gcnt++;
    gnt = !stall || (gcnt % 3 != 1);
  end

  ldma_channel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .first_desc_i(first_desc),
    .unalign_ok_i(unal), .periph_req_i(periph),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(size),
    .mem_wdata_o(wdata), .mem_gnt_i(gnt), .mem_rdata_i(rdata), .mem_err_i(err),
    .start_evt_o(start_evt), .end_evt_o(end_evt), .buserr_evt_o(buserr_evt),
    .stopped_o(stopped)
  );

  typedef struct {
    bit        we;
    bit [31:0] addr;
    bit [31:0] data;
    bit [1:0]  size;
    int        rq;
  } acc_t;
  acc_t expq[$];

  int checks = 0, fails = 0;
  int n_start = 0, n_end = 0, n_err = 0, n_acc = 0, n_wr = 0;
  int exp_start = 0, exp_end = 0;
  bit tolerate = 0;
  bit done = 0;

  localparam logic [31:0] C_INCS = 32'h8000_0000, C_INCT = 32'h4000_0000,
                          C_FLS = 32'h2000_0000, C_IRQS = 32'h0040_0000,
                          C_IRQE = 32'h0020_0000, C_SWAP = 32'h0004_0000,
                          W_B = 32'h0000_4000, W_H = 32'h0000_8000, W_W = 32'h0000_C000,
                          B8 = 32'h0001_0000, B32 = 32'h0003_0000;

  task automatic chk(input bit c, input string msg);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic setd(input int slot, input logic [31:0] nx, s, t, c);
    dmem[slot*4]   = nx;
    dmem[slot*4+1] = s;
    dmem[slot*4+2] = t;
    dmem[slot*4+3] = c;
  endtask

  // behavioural expectation of the access stream
  task automatic build(input logic [31:0] first, input int max_desc, input bit ua);
    logic [31:0] p, nx, s, t, c;
    int w, rem;
    acc_t a;
    p = first & ~32'hF;
    for (int n = 0; n < max_desc; n++) begin
      for (int k = 0; k < 4; k++) begin
        a.we = 0; a.addr = p + 32'(4 * k); a.data = 0; a.size = 2'd3; a.rq = 1;
        expq.push_back(a);
      end
      nx = dmem[p[7:2]];
      s  = dmem[p[7:2] + 6'd1];
      t  = dmem[p[7:2] + 6'd2];
      c  = dmem[p[7:2] + 6'd3];
      if (!ua) begin s = s & ~32'h7; t = t & ~32'h7; end
      w   = (c[15:14] == 2'd0) ? 4 : (1 << (int'(c[15:14]) - 1));
      rem = int'(c[12:0]);
      exp_start += int'(c[22]);
      exp_end   += int'(c[21]);
      while (rem > 0) begin
        a.we = 0; a.addr = s; a.data = 0;
        a.size = (c[15:14] == 2'd0) ? 2'd3 : c[15:14]; a.rq = 2;
        expq.push_back(a);
        a.we = 1; a.addr = t; a.data = c[18] ? bswap(pat(s)) : pat(s);
        a.rq = c[18] ? 10 : 3;
        expq.push_back(a);
        if (c[31]) s = s + 32'(w);
        if (c[30]) t = t + 32'(w);
        rem -= w;
      end
      if (nx[0]) break;
      p = nx & ~32'hF;
    end
  endtask

  // compares every granted access with the head of the expected queue
  always @(negedge clk) begin
    acc_t a;
    #2;
    if (rst_ni && !done) begin
      if (start_evt)  n_start++;
      if (end_evt)    n_end++;
      if (buserr_evt) n_err++;
      if (req && gnt) begin
        n_acc++;
        if (we) n_wr++;
        if (expq.size() == 0) begin
          if (!tolerate)
            chk(0, $sformatf("R4 unexpected access addr=%h we=%0d expected none", addr, we));
        end else begin
          a = expq.pop_front();
          chk(we == a.we && addr == a.addr && size == a.size && (!a.we || wdata == a.data),
              $sformatf("R%0d access act we=%0d addr=%h size=%0d data=%h exp we=%0d addr=%h size=%0d data=%h",
                        a.rq, we, addr, size, wdata, a.we, a.addr, a.size, a.data));
        end
      end
    end
  end

  task automatic clr_counts();
    n_start = 0; n_end = 0; n_err = 0; n_acc = 0; n_wr = 0;
    exp_start = 0; exp_end = 0;
  endtask

  task automatic start(input logic [31:0] p, input bit ua);
    @(negedge clk);
    first_desc = p; unal = ua; run = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      if (stopped && expq.size() == 0) break;
      @(negedge clk);
    end
    chk(stopped && expq.size() == 0,
        $sformatf("R4 chain end act stopped=%0d left=%0d exp stopped=1 left=0", stopped, expq.size()));
  endtask

  task automatic halt_run();
    @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    // R13 reset state
    chk(stopped && !req && !start_evt && !end_evt && !buserr_evt,
        $sformatf("R13 reset act stopped=%0d req=%0d exp stopped=1 req=0", stopped, req));

    // two-descriptor chain with grant stalls: R1 R2 R3 R4 R6 R10
    setd(0, 32'h20, 32'h1000, 32'h2000, C_INCS | C_INCT | W_W | B32 | C_IRQS | C_IRQE | 32'd12);
    setd(2, 32'h1,  32'h1100, 32'h2100, C_INCS | W_H | B8 | C_IRQE | C_SWAP | 32'd5);
    clr_counts(); stall = 1;
    build(32'h0, 8, 1'b1);
    start(32'h0, 1'b1);
    wait_done();
    chk(n_wr == 6, $sformatf("R2 element count act=%0d exp=6", n_wr));
    chk(n_start == exp_start, $sformatf("R6 start events act=%0d exp=%0d", n_start, exp_start));
    chk(n_end == exp_end, $sformatf("R6 end events act=%0d exp=%0d", n_end, exp_end));
    halt_run(); stall = 0;

    // zero length then fixed-address bytes: R7 R3
    setd(4, 32'h50, 32'h1200, 32'h2200, C_IRQE);
    setd(5, 32'h1,  32'h1300, 32'h2300, W_B | C_IRQS | 32'd3);
    clr_counts();
    build(32'h40, 8, 1'b1);
    start(32'h40, 1'b1);
    wait_done();
    chk(n_wr == 3, $sformatf("R7 data writes act=%0d exp=3", n_wr));
    chk(n_end == 1 && n_start == 1, $sformatf("R7 events act end=%0d start=%0d exp 1 1", n_end, n_start));
    halt_run();

    // alignment control both ways: R9
    setd(6, 32'h1, 32'h1405, 32'h240B, C_INCS | C_INCT | W_W | 32'd8);
    clr_counts();
    build(32'h60, 8, 1'b0);
    start(32'h60, 1'b0);
    wait_done();
    halt_run();
    clr_counts();
    build(32'h60, 8, 1'b1);
    start(32'h60, 1'b1);
    wait_done();
    chk(n_wr == 2, $sformatf("R9 unaligned writes act=%0d exp=2", n_wr));
    halt_run();

    // peripheral pacing, 2 elements per burst: R8
    setd(8, 32'h1, 32'h3000, 32'h4000, C_FLS | C_INCS | W_W | B8 | 32'd16);
    clr_counts(); periph = 1'b0;
    build(32'h80, 8, 1'b1);
    start(32'h80, 1'b1);
    repeat (20) @(negedge clk);
    chk(n_wr == 0, $sformatf("R8 no burst without request act=%0d exp=0", n_wr));
    periph = 1'b1;
    @(negedge clk);
    periph = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_wr == 2, $sformatf("R8 one burst per request act=%0d exp=2", n_wr));
    periph = 1'b1;
    wait_done();
    chk(n_wr == 4, $sformatf("R8 total writes act=%0d exp=4", n_wr));
    halt_run();

    // circular chain, three laps: R5
    setd(10, 32'hB0, 32'h5000, 32'h6000, C_INCS | C_INCT | W_W | C_IRQE | 32'd8);
    setd(11, 32'hA0, 32'h5100, 32'h6100, C_INCS | C_INCT | W_W | C_IRQE | 32'd8);
    clr_counts(); tolerate = 1;
    build(32'hA0, 6, 1'b1);
    start(32'hA0, 1'b1);
    for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_end == 6, $sformatf("R5 end per pass act=%0d exp=6", n_end));
    chk(stopped, $sformatf("R5 stop on run low act=%0d exp=1", stopped));
    tolerate = 0; expq.delete();

    // run dropped mid-transfer: R12
    setd(12, 32'h1, 32'h7000, 32'h7800, C_INCS | C_INCT | W_W | 32'd400);
    clr_counts(); stall = 1;
    build(32'hC0, 1, 1'b1);
    start(32'hC0, 1'b1);
    repeat (30) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    c0 = n_acc;
    expq.delete();
    repeat (10) @(negedge clk);
    chk(n_acc == c0 && stopped, $sformatf("R12 quiet act acc=%0d stopped=%0d exp acc=%0d stopped=1", n_acc, stopped, c0));
    stall = 0;

    // bus error on third data read: R11
    setd(13, 32'hE0, 32'h8000, 32'h8800, C_INCS | C_INCT | W_W | C_IRQE | 32'd16);
    clr_counts();
    err_addr = 32'h8008; err_en = 1;
    build(32'hD0, 1, 1'b1);
    while (expq.size() > 0 && !(expq[$].addr == 32'h8008 && !expq[$].we)) void'(expq.pop_back());
    start(32'hD0, 1'b1);
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, $sformatf("R11 accesses before error left=%0d exp=0", expq.size()));
    chk(n_err == 1, $sformatf("R11 error events act=%0d exp=1", n_err));
    chk(n_end == 0, $sformatf("R11 no end event act=%0d exp=0", n_end));
    c0 = n_acc;
    repeat (10) @(negedge clk);
    chk(stopped && n_acc == c0, $sformatf("R11 halted act stopped=%0d acc=%0d exp 1 %0d", stopped, n_acc, c0));
    halt_run();
    err_en = 0;
    dmem[13*4] = 32'h1;
    clr_counts();
    build(32'hD0, 4, 1'b1);
    start(32'hD0, 1'b1);
    wait_done();
    chk(n_wr == 4, $sformatf("R11 restart after run cycle act=%0d exp=4", n_wr));
    halt_run();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule